// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides when a timer channel's counter advances. It emits a one-cycle count-enable pulse in the system clock domain. The pulse comes from one of eight sources. Five are internal rates taken from a shared free-running prescaler, and three are external clock lines. The external lines are brought into the system clock domain and reduced to one pulse per edge.

A select field picks the source. An edge-invert control moves counting to the opposite edge of the chosen clock. A gate field can hold counting off while a chosen external line is low. A companion flag reports whether the gate currently lets counts through.

The counter channel that consumes the pulse owns starting, stopping and triggering. This block only decides which cycles carry a count.

External clocks must hold each level for more than one system clock period. Their frequency must not exceed the system clock divided by 2.5.

Top module: `timer_clk_select`

## Requirements
- R1: With `srcSel` at 0, 1, 2, 3 or 4 and `invertEdge` low, `tick` pulses once every 2, 8, 32, 128 or 1024 cycles respectively. A tick is seen after the clock edge at which the prescaler's low log2(divide) bits were all ones. The prescaler is 0 before the first edge after reset and increments on every edge.
- R2: With `srcSel` at 5, 6 or 7, the source is `extClk[0]`, `extClk[1]` or `extClk[2]`. Each input passes through two synchronizing flops. One `tick` appears per rising edge, on the third clock edge after the input change is first sampled.
- R3: With `invertEdge` high, an external source ticks on its falling edges, with the same latency as R2. An internal source ticks when the prescaler's low bits equal half the divide ratio minus one. Its rate is unchanged and its phase moves by half a period.
- R4: `gateSel` 0 disables gating. `gateSel` 1, 2 and 3 gate with the synchronized level of `extClk[0]`, `extClk[1]` and `extClk[2]`. While that level is low, no `tick` is produced.
- R5: `clkValid` is high when the gate is open. This is always the case with `gateSel` 0; otherwise it follows the synchronized gate level. It is registered with the same one-edge delay as `tick`, so a tick never appears without `clkValid`.
- R6: Changing `srcSel` or `invertEdge` produces no tick of its own. A tick occurs only when the newly selected source has its own edge or divide event.
- R7: While `rstN` is low, `tick` and `clkValid` are 0. After release the prescaler restarts from 0, so divide-by-8 first ticks after the eighth clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 3 | Count source: 0-4 internal rates /2,/8,/32,/128,/1024; 5-7 external lines 0-2 |
| invertEdge | input | 1 | Count on the opposite edge of the selected source |
| gateSel | input | 2 | Gate signal: 0 none, 1-3 external line 0-2 |
| extClk | input | 3 | External clock / gate lines, asynchronous |
| tick | output | 1 | One-cycle count-enable pulse |
| clkValid | output | 1 | Gate currently lets counts through |

## Verification
The bench targets three things:

- **Divider phases.** The bench checks the phase of every divider in both edge senses. A prescaler tapped at the wrong bit would shift or stretch the ticks. An invert that was ignored on internal rates would leave the phase unchanged.
- **External-clock latency.** The bench checks the exact three-edge latency of external clocks and the polarity of the edge detector. A missing synchronizer stage, or a detector keyed on level rather than edge, shows up as early ticks or as a run of consecutive ticks.
- **Selection and gating.** The bench sweeps the select field across external lines held at differing static levels. Logic that compares raw levels across the switch would emit spurious ticks. Gating with a closed gate must suppress everything. A reset mid-run must restart the divide phase from zero.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int NUM_DIV   = 5;
  localparam int NUM_EXT   = 3;
  localparam int SEL_W     = 3;
  localparam int GATE_W    = 2;
  localparam int EXT_IDX_W = 2;

  // log2 of each internal divide ratio, ascending
  function automatic int divExp(input int idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      2:       return 5;
      3:       return 7;
      default: return 10;
    endcase
  endfunction

  localparam int PRE_W = divExp(NUM_DIV - 1);

  // strobes handed from the datapath to the control
  typedef struct packed {
    logic [NUM_DIV-1:0] divRise;
    logic [NUM_DIV-1:0] divHalf;
    logic [NUM_EXT-1:0] extRise;
    logic [NUM_EXT-1:0] extFall;
    logic [NUM_EXT-1:0] extLevel;
  } tcsStrobes_t;

endpackage

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extClk,
  output tcsStrobes_t        strb
);

  logic [PRE_W-1:0]   preCnt;
  logic [NUM_DIV-1:0] divRise;
  logic [NUM_DIV-1:0] divHalf;
  logic [NUM_EXT-1:0] extRise;
  logic [NUM_EXT-1:0] extFall;
  logic [NUM_EXT-1:0] extLevel;

  // shared free-running prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  generate
    for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_div
      localparam int K = divExp(gi);
      localparam logic [K-1:0] HALF_PAT = K'((1 << (K - 1)) - 1);
      assign divRise[gi] = &preCnt[K-1:0];
      assign divHalf[gi] = (preCnt[K-1:0] == HALF_PAT);
    end

    for (genvar gx = 0; gx < NUM_EXT; gx++) begin : g_ext
      logic [SYNC_STAGES:0] shReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shReg <= '0;
        else       shReg <= {shReg[SYNC_STAGES-1:0], extClk[gx]};
      end
      assign extLevel[gx] = shReg[SYNC_STAGES-1];
      assign extRise[gx]  = shReg[SYNC_STAGES-1] & ~shReg[SYNC_STAGES];
      assign extFall[gx]  = ~shReg[SYNC_STAGES-1] & shReg[SYNC_STAGES];
    end
  endgenerate

  assign strb = {divRise, divHalf, extRise, extFall, extLevel};

  // divide-by-2 strobe alternates every cycle
  AST_DIV2_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    divRise[0] |=> !divRise[0]); // R1

endmodule

// File: rtl/tcs_control.sv
module tcs_control
  import tcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic              invertEdge,
  input  logic [GATE_W-1:0] gateSel,
  input  tcsStrobes_t       strb,
  output logic              tick,
  output logic              clkValid
);

  localparam logic [SEL_W-1:0] FIRST_EXT = SEL_W'(NUM_DIV);

  logic                 isExt;
  logic [EXT_IDX_W-1:0] extIdx;
  logic [EXT_IDX_W-1:0] gateIdx;
  logic                 selEvent;
  logic                 gateOpen;

  always_comb begin
    isExt   = (srcSel >= FIRST_EXT);
    extIdx  = EXT_IDX_W'(srcSel - FIRST_EXT);
    gateIdx = EXT_IDX_W'(gateSel - 1'b1);
    if (isExt) selEvent = invertEdge ? strb.extFall[extIdx] : strb.extRise[extIdx];
    else       selEvent = invertEdge ? strb.divHalf[srcSel] : strb.divRise[srcSel];
    gateOpen = (gateSel == '0) || strb.extLevel[gateIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick     <= 1'b0;
      clkValid <= 1'b0;
    end else begin
      tick     <= selEvent & gateOpen;
      clkValid <= gateOpen;
    end
  end

  AST_EXT_RISE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (isExt && !invertEdge && strb.extRise[extIdx] && gateOpen) |=> tick); // R2

  AST_EXT_FALL_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (isExt && invertEdge && strb.extFall[extIdx] && gateOpen) |=> tick); // R3

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (gateSel != '0 && !strb.extLevel[gateIdx]) |=> !tick); // R4

  AST_UNGATED_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (gateSel == '0) |=> clkValid); // R5

endmodule

// File: rtl/timer_clk_select.sv
module timer_clk_select
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               invertEdge,
  input  logic [GATE_W-1:0]  gateSel,
  input  logic [NUM_EXT-1:0] extClk,
  output logic               tick,
  output logic               clkValid
);

  tcsStrobes_t strb;

  tcs_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .extClk (extClk),
    .strb   (strb)
  );

  tcs_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .srcSel     (srcSel),
    .invertEdge (invertEdge),
    .gateSel    (gateSel),
    .strb       (strb),
    .tick       (tick),
    .clkValid   (clkValid)
  );

endmodule

// File: tb/timer_clk_select_bench.sv
`timescale 1ns/1ps
module timer_clk_select_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] srcSel = 3'd0;
  logic       invertEdge = 1'b0;
  logic [1:0] gateSel = 2'd0;
  logic [2:0] extClk = 3'b000;
  logic       tick;
  logic       clkValid;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R7";

  bit         extRun = 1'b0;
  logic [2:0] extStatic = 3'b000;
  int         halfPer[3] = '{2, 3, 5};
  int         tcyc = 0;

  logic       expTick = 1'b0;
  logic       expValid = 1'b0;
  int         mCnt = 0;
  logic [2:0] hist[$] = '{3'b000, 3'b000, 3'b000};
  int         tickCount = 0;
  logic       ev, gOk;
  int         dv, xi;

  timer_clk_select u_timer_clk_select (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .invertEdge(invertEdge),
    .gateSel(gateSel), .extClk(extClk), .tick(tick), .clkValid(clkValid)
  );

  always #10 clk = ~clk;

  function automatic int divOf(input int s);
    return 1 << ((s == 4) ? 10 : 2 * s + 1);
  endfunction

  // behavioural reference model, evaluated on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      expTick = 1'b0; expValid = 1'b0; mCnt = 0;
      hist = '{3'b000, 3'b000, 3'b000};
    end else begin
      if (srcSel < 3'd5) begin
        dv = divOf(int'(srcSel));
        ev = invertEdge ? ((mCnt % dv) == dv / 2 - 1) : ((mCnt % dv) == dv - 1);
      end else begin
        xi = int'(srcSel) - 5;
        ev = invertEdge ? (!hist[1][xi] && hist[2][xi]) : (hist[1][xi] && !hist[2][xi]);
      end
      gOk = (gateSel == 2'd0) ? 1'b1 : hist[1][int'(gateSel) - 1];
      expTick = ev && gOk;
      expValid = gOk;
      mCnt++;
      hist.push_front(extClk);
      void'(hist.pop_back());
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (tick !== expTick || clkValid !== expValid) begin
        fails++;
        $display("FAIL %s: tick=%b clkValid=%b expected tick=%b clkValid=%b",
                 curReq, tick, clkValid, expTick, expValid);
      end
      if (tick) tickCount++;
    end
  end

  // external line driver
  always @(negedge clk) begin
    tcyc++;
    if (extRun)
      for (int i = 0; i < 3; i++) extClk[i] = ((tcyc / halfPer[i]) % 2) != 0;
    else
      extClk = extStatic;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic window(input int n);
    @(negedge clk); #1 tickCount = 0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int firstN;
    // R7: reset state
    repeat (3) @(negedge clk);
    #1 chk(tick == 1'b0, "R7", tick, 0);
    chk(clkValid == 1'b0, "R7", clkValid, 0);
    #2 rstN = 1'b1;

    // R1: internal rates
    curReq = "R1";
    for (int s = 0; s < 5; s++) begin
      @(negedge clk); srcSel = 3'(s);
      window(2048);
      chk(tickCount == 2048 / divOf(s), "R1", tickCount, 2048 / divOf(s));
    end

    // R3: inverted internal rates
    curReq = "R3";
    invertEdge = 1'b1;
    for (int s = 0; s < 5; s++) begin
      @(negedge clk); srcSel = 3'(s);
      window(2048);
      chk(tickCount == 2048 / divOf(s), "R3", tickCount, 2048 / divOf(s));
    end

    // R2: external clocks, rising edges
    curReq = "R2";
    invertEdge = 1'b0; extRun = 1'b1;
    for (int s = 5; s < 8; s++) begin
      @(negedge clk); srcSel = 3'(s);
      window(600);
      chk(tickCount >= 600 / (2 * halfPer[s-5]) - 1 && tickCount <= 600 / (2 * halfPer[s-5]) + 1,
          "R2", tickCount, 600 / (2 * halfPer[s-5]));
    end

    // R3: external clocks, falling edges
    curReq = "R3";
    invertEdge = 1'b1;
    for (int s = 5; s < 8; s++) begin
      @(negedge clk); srcSel = 3'(s);
      window(600);
      chk(tickCount >= 600 / (2 * halfPer[s-5]) - 1 && tickCount <= 600 / (2 * halfPer[s-5]) + 1,
          "R3", tickCount, 600 / (2 * halfPer[s-5]));
    end

    // R4: gating with toggling lines
    curReq = "R4";
    invertEdge = 1'b0; srcSel = 3'd0;
    for (int g = 1; g < 4; g++) begin
      @(negedge clk); gateSel = 2'(g);
      window(300);
      chk(tickCount > 0, "R4", tickCount, 1);
    end

    // R4: closed gate suppresses everything
    extRun = 1'b0; extStatic = 3'b000; gateSel = 2'd1;
    repeat (5) @(negedge clk);
    window(20);
    chk(tickCount == 0, "R4", tickCount, 0);
    // R5: flag follows gate
    chk(clkValid == 1'b0, "R5", clkValid, 0);
    extStatic = 3'b001;
    repeat (5) @(negedge clk); #1;
    chk(clkValid == 1'b1, "R5", clkValid, 1);
    curReq = "R5";
    gateSel = 2'd3;
    repeat (5) @(negedge clk); #1;
    chk(clkValid == 1'b0, "R5", clkValid, 0);
    gateSel = 2'd0;
    repeat (2) @(negedge clk); #1;
    chk(clkValid == 1'b1, "R5", clkValid, 1);

    // R6: select and edge changes over static lines
    curReq = "R6";
    extStatic = 3'b101;
    srcSel = 3'd5;
    repeat (8) @(negedge clk);
    #1 tickCount = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      srcSel = 3'(5 + (k % 3));
      invertEdge = k[1];
      @(negedge clk);
    end
    #1 chk(tickCount == 0, "R6", tickCount, 0);

    // R7: reset mid-run restarts the prescaler
    curReq = "R7";
    invertEdge = 1'b0; srcSel = 3'd1;
    repeat (5) @(negedge clk);
    #3 rstN = 1'b0;
    @(negedge clk); #1;
    chk(tick == 1'b0 && clkValid == 1'b0, "R7", {tick, clkValid}, 0);
    @(negedge clk); #3 rstN = 1'b1;
    firstN = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk); #1;
      if (tick && firstN == 0) firstN = n;
    end
    chk(firstN == 8, "R7", firstN, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule